// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Bank

This block holds the digital state behind a four-channel, 16-bit voltage-output converter. Each channel has two register ranks. The front rank receives data from the serial bus. The back rank drives the analog output stage. Words arrive already decoded from an upstream two-wire slave, one per completed 24-bit frame. Each word carries a channel number, a 16-bit data value and a flag that asks for the output to change at once or to wait.

An active-low load strobe moves waiting data from the front rank to the back rank. A static mode input decides how the strobe is read. In the edge mode the end of a low pulse transfers every waiting channel, and a strobe held low lets each write pass straight through to the back rank. In the frame mode the strobe level is sampled only when a frame completes. A power-on reset and a falling edge on a separate clear input load the same code into both ranks. A strap input picks that code, either zero scale or midscale. The block also holds a per-channel power-down mask. The strobe and clear inputs are asynchronous pins, so each passes through a two-stage synchronizer.

Top module: `qdac_bank`

## Requirements
- R1: After power-on reset (`rst_n` low, then released), every channel's front and back registers hold 16'h0000 if `strap_mid` is 0, or 16'h8000 if it is 1. The code is on `dac_out` by the third rising clock edge after release. `pd_out` reads 4'b0000.
- R2: A falling edge on `clr_n` loads the strap-selected code into both ranks of all four channels and discards any waiting data. `dac_out` shows the code on the third rising edge after the fall. `pd_out` is not affected.
- R3: In edge mode (`sync_mode`=0) with the strobe high, a write with `wr_update`=0 changes only the front register of that channel. `dac_out` does not change, and the channel is marked as waiting.
- R4: A write with `wr_update`=1 places `wr_data` on that channel's `dac_out` field at the next rising edge, in either mode and whatever the strobe level.
- R5: In edge mode, the rise of `ld_n` that ends a low pulse copies the front register to `dac_out` for every waiting channel, all on the same edge: the third rising edge after the rise. Channels that are not waiting keep their output.
- R6: In edge mode, while `ld_n` is held low, each write goes directly to `dac_out` at the next edge, as if `wr_update` were 1.
- R7: While `clr_n` is held low, `ld_n` has no effect. A rise does not transfer, and a held-low strobe does not pass writes through. A write made in that time stays waiting until a strobe after `clr_n` returns high.
- R8: In frame mode (`sync_mode`=1), a rise of `ld_n` on its own does nothing. A write completed while the synchronized strobe is low transfers all waiting channels, and the written channel, on that write's edge.
- R9: `pd_we`=1 loads `pd_mask_in` into `pd_out` at the next edge, with bit k covering channel k. With `pd_we`=0 the mask holds.
- R10: `wr_ch` value k selects channel k (0=A … 3=D). Channel k appears on `dac_out[16k+15:16k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| clr_n | input | 1 | Clear pin, acts on its falling edge, asynchronous |
| strap_mid | input | 1 | Reset code select: 0 zero scale, 1 midscale |
| ld_n | input | 1 | Load strobe, active low, asynchronous |
| sync_mode | input | 1 | Strobe mode: 0 edge, 1 sampled at frame completion |
| wr_valid | input | 1 | One-cycle pulse: a decoded frame is complete |
| wr_ch | input | 2 | Target channel of the write |
| wr_data | input | 16 | Data of the write |
| wr_update | input | 1 | 1: update the output now; 0: hold in front rank |
| pd_we | input | 1 | Load enable for the power-down mask |
| pd_mask_in | input | 4 | New power-down mask, bit k for channel k |
| dac_out | output | 64 | Back-rank values, channel k at bits 16k+15:16k |
| pd_out | output | 4 | Power-down mask |

## Verification
A write, with or without update, and a power-down mask load show at the ports on the first rising edge after the input is driven. Every change that starts at the asynchronous pins `ld_n` or `clr_n` needs three edges: two for synchronization and one for the register update. Power-on needs three edges after release. The bench drives every input on a falling edge and samples on falling edges. For each pin-driven event it checks once on the second falling edge, where nothing may yet have moved, and again on the third, where the result must be present. A reference model in the bench tracks the front rank, back rank and waiting flag of each channel from the requirements alone.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_FRAME = 1'b1
  } ld_mode_e;

  // Per-cycle commands broadcast from the strobe controller to every channel
  typedef struct packed {
    logic load_code;  // force strap code into both ranks
    logic xfer_all;   // move every waiting channel to its back rank
    logic pass_thru;  // writes go straight to the back rank
  } ch_ctl_t;

endpackage

// File: rtl/qdac_sync2.sv
module qdac_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/qdac_strobe_ctl.sv
module qdac_strobe_ctl
  import qdac_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ld_n,
  input  logic    clr_n,
  input  logic    sync_mode,
  input  logic    wr_valid,
  output ch_ctl_t ctl
);

  logic ld_s;
  logic clr_s;
  logic ld_prev_q, clr_prev_q, por_q;
  logic ld_prev_d, clr_prev_d, por_d;
  logic ld_rise, clr_fall, clr_held;
  ld_mode_e mode;

  qdac_sync2 #(.RST_VAL(1'b1)) u_ld_sync (
    .clk(clk), .rst_n(rst_n), .d(ld_n), .q(ld_s)
  );

  qdac_sync2 #(.RST_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .d(clr_n), .q(clr_s)
  );

  assign mode = ld_mode_e'(sync_mode);

  always_comb begin
    ld_prev_d  = ld_s;
    clr_prev_d = clr_s;
    por_d      = 1'b0;
    ld_rise    = ld_s & ~ld_prev_q;
    clr_fall   = clr_prev_q & ~clr_s;
    clr_held   = ~clr_s;

    ctl.load_code = por_q | clr_fall;
    ctl.xfer_all  = 1'b0;
    ctl.pass_thru = 1'b0;
    if (!clr_held) begin
      if (mode == MODE_FRAME) begin
        ctl.xfer_all = wr_valid & ~ld_s;
      end else begin
        ctl.xfer_all  = ld_rise;
        ctl.pass_thru = ~ld_s;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q  <= 1'b1;
      clr_prev_q <= 1'b1;
      por_q      <= 1'b1;
    end else begin
      ld_prev_q  <= ld_prev_d;
      clr_prev_q <= clr_prev_d;
      por_q      <= por_d;
    end
  end

  AST_CLR_BLOCKS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |-> !(ctl.xfer_all || ctl.pass_thru)); // R7

  AST_FRAME_XFER_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ctl.xfer_all) |-> wr_valid); // R8

  AST_EDGE_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && ctl.xfer_all) |=> !(ctl.xfer_all && !sync_mode)); // R5

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
  import qdac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ch_ctl_t           ctl,
  input  logic [DATA_W-1:0] code_i,
  input  logic              wr_hit,
  input  logic              wr_update,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dac_o
);

  logic [DATA_W-1:0] in_q, in_d;
  logic [DATA_W-1:0] dac_q, dac_d;
  logic              pend_q, pend_d;
  logic              direct;

  always_comb begin
    in_d   = wr_hit ? wr_data : in_q;
    dac_d  = dac_q;
    pend_d = pend_q;
    direct = wr_hit & (wr_update | ctl.pass_thru);
    if (ctl.load_code) begin
      in_d   = code_i;
      dac_d  = code_i;
      pend_d = 1'b0;
    end else if (direct) begin
      dac_d  = wr_data;
      pend_d = 1'b0;
    end else if (ctl.xfer_all && (pend_q || wr_hit)) begin
      dac_d  = in_d;
      pend_d = 1'b0;
    end else if (wr_hit) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      in_q   <= in_d;
      dac_q  <= dac_d;
      pend_q <= pend_d;
    end
  end

  assign dac_o = dac_q;

  AST_CODE_BOTH_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load_code |=> (dac_q == $past(code_i) && in_q == $past(code_i) && !pend_q)); // R2

  AST_UPDATE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_update && !ctl.load_code) |=> dac_q == $past(wr_data)); // R4

  AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !wr_update && !ctl.load_code && !ctl.xfer_all && !ctl.pass_thru)
      |=> (pend_q && $stable(dac_q))); // R3

  AST_XFER_CLEARS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.xfer_all && pend_q) |=> !pend_q); // R5

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  logic                     strap_mid,
  input  logic                     ld_n,
  input  logic                     sync_mode,
  input  logic                     wr_valid,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_update,
  input  logic                     pd_we,
  input  logic [NUM_CH-1:0]        pd_mask_in,
  output logic [NUM_CH*DATA_W-1:0] dac_out,
  output logic [NUM_CH-1:0]        pd_out
);

  localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

  logic              rs1_q, rs2_q;
  logic              rst_sync_n;
  ch_ctl_t           ctl;
  logic [DATA_W-1:0] code;
  logic [NUM_CH-1:0] pd_q, pd_d;

  // Reset asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  assign code = strap_mid ? MID_CODE : '0;

  qdac_strobe_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld_n      (ld_n),
    .clr_n     (clr_n),
    .sync_mode (sync_mode),
    .wr_valid  (wr_valid),
    .ctl       (ctl)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit = wr_valid && (wr_ch == CH_W'(k));
    qdac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ctl       (ctl),
      .code_i    (code),
      .wr_hit    (hit),
      .wr_update (wr_update),
      .wr_data   (wr_data),
      .dac_o     (dac_out[k*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    pd_d = pd_q;
    if (pd_we) begin
      pd_d = pd_mask_in;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pd_q <= '0;
    end else begin
      pd_q <= pd_d;
    end
  end

  assign pd_out = pd_q;

  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pd_we |=> $stable(pd_q)); // R9

  AST_PD_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pd_we |=> pd_q == $past(pd_mask_in)); // R9

endmodule

// File: tb/qdac_bank_tb.sv
module qdac_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n, clr_n, strap_mid, ld_n, sync_mode;
  logic        wr_valid, wr_update, pd_we;
  logic [1:0]  wr_ch;
  logic [15:0] wr_data;
  logic [3:0]  pd_mask_in;
  logic [63:0] dac_out;
  logic [3:0]  pd_out;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] m_in  [NCH];
  logic [15:0] m_dac [NCH];
  logic        m_pend[NCH];
  logic [3:0]  m_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_bank u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .strap_mid(strap_mid),
    .ld_n(ld_n), .sync_mode(sync_mode), .wr_valid(wr_valid), .wr_ch(wr_ch),
    .wr_data(wr_data), .wr_update(wr_update), .pd_we(pd_we),
    .pd_mask_in(pd_mask_in), .dac_out(dac_out), .pd_out(pd_out)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_dacs(string tag);
    for (int k = 0; k < NCH; k++)
      chk($sformatf("%s ch%0d", tag, k), dac_out[16*k +: 16], m_dac[k]);
  endtask

  task automatic m_load(logic [15:0] c);
    for (int k = 0; k < NCH; k++) begin
      m_in[k] = c; m_dac[k] = c; m_pend[k] = 1'b0;
    end
  endtask

  task automatic m_xfer();
    for (int k = 0; k < NCH; k++)
      if (m_pend[k]) begin
        m_dac[k] = m_in[k]; m_pend[k] = 1'b0;
      end
  endtask

  // Called on a falling edge; returns on the next falling edge
  task automatic wr(int ch, logic [15:0] d, logic upd);
    wr_valid = 1'b1; wr_ch = ch[1:0]; wr_data = d; wr_update = upd;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Low pulse on ld_n; checks that nothing moved at 2 edges after the rise
  task automatic ld_pulse(string tag);
    ld_n = 1'b0;
    wait_n(4);
    ld_n = 1'b1;
    wait_n(2);
    check_dacs({tag, " early"});
    wait_n(1);
  endtask

  task automatic do_por(logic mid, string tag);
    strap_mid = mid;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    m_load(mid ? 16'h8000 : 16'h0000);
    m_pd = 4'b0000;
    check_dacs(tag);
    chk({tag, " pd"}, {12'h0, pd_out}, {12'h0, m_pd});
  endtask

  task automatic t_hold_write();
    wr(2, 16'h1234, 1'b0);
    m_in[2] = 16'h1234; m_pend[2] = 1'b1;
    check_dacs("R3 hold write");
  endtask

  task automatic t_update_write();
    wr(1, 16'hBEEF, 1'b0 | 1'b1);
    m_in[1] = 16'hBEEF; m_dac[1] = 16'hBEEF; m_pend[1] = 1'b0;
    check_dacs("R4 R10 update write");
  endtask

  task automatic t_strobe();
    wr(0, 16'h0F0F, 1'b0); m_in[0] = 16'h0F0F; m_pend[0] = 1'b1;
    wr(3, 16'hC3C3, 1'b0); m_in[3] = 16'hC3C3; m_pend[3] = 1'b1;
    check_dacs("R3 before strobe");
    ld_pulse("R5 strobe");
    m_xfer();
    check_dacs("R5 strobe");
  endtask

  task automatic t_pass();
    ld_n = 1'b0;
    wait_n(3);
    wr(3, 16'h5A5A, 1'b0);
    m_in[3] = 16'h5A5A; m_dac[3] = 16'h5A5A;
    check_dacs("R6 pass through");
    ld_n = 1'b1;
    wait_n(4);
    check_dacs("R6 after release");
  endtask

  task automatic t_pd();
    pd_mask_in = 4'b0101; pd_we = 1'b1;
    @(negedge clk);
    pd_we = 1'b0; m_pd = 4'b0101;
    chk("R9 pd load", {12'h0, pd_out}, {12'h0, m_pd});
    pd_mask_in = 4'b1010;
    wait_n(2);
    chk("R9 pd hold", {12'h0, pd_out}, {12'h0, m_pd});
  endtask

  task automatic t_clr();
    wr(0, 16'h7777, 1'b0); m_in[0] = 16'h7777; m_pend[0] = 1'b1;
    strap_mid = 1'b1;
    clr_n = 1'b0;
    wait_n(2);
    check_dacs("R2 clr early");
    wait_n(1);
    m_load(16'h8000);
    check_dacs("R2 clr loads code");
    chk("R2 pd kept", {12'h0, pd_out}, {12'h0, m_pd});
  endtask

  task automatic t_clr_hold();
    ld_pulse("R7 ignored pulse");
    check_dacs("R7 pulse during clr");
    ld_n = 1'b0;
    wait_n(3);
    wr(1, 16'h1111, 1'b0);
    m_in[1] = 16'h1111; m_pend[1] = 1'b1;
    check_dacs("R7 no pass through");
    ld_n = 1'b1;
    wait_n(4);
    check_dacs("R7 release ignored");
    clr_n = 1'b1;
    wait_n(4);
    check_dacs("R7 clr rise");
    ld_pulse("R7 after clr");
    m_xfer();
    check_dacs("R7 waiting data moved");
  endtask

  task automatic t_frame();
    sync_mode = 1'b1;
    wr(0, 16'hA0A0, 1'b0); m_in[0] = 16'hA0A0; m_pend[0] = 1'b1;
    ld_pulse("R8 pulse alone");
    check_dacs("R8 pulse alone");
    ld_n = 1'b0;
    wait_n(3);
    wr(2, 16'h0C0C, 1'b0);
    m_in[2] = 16'h0C0C; m_pend[2] = 1'b1;
    m_xfer();
    check_dacs("R8 frame transfer");
    ld_n = 1'b1;
    wait_n(4);
    check_dacs("R8 after release");
    wr(3, 16'hD00D, 1'b1);
    m_in[3] = 16'hD00D; m_dac[3] = 16'hD00D;
    check_dacs("R4 update in frame mode");
    sync_mode = 1'b0;
    wait_n(2);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; strap_mid = 1'b0; ld_n = 1'b1;
    sync_mode = 1'b0; wr_valid = 1'b0; wr_ch = '0; wr_data = '0;
    wr_update = 1'b0; pd_we = 1'b0; pd_mask_in = '0;
    m_pd = '0;
    @(negedge clk);
    do_por(1'b0, "R1 por zero");
    t_hold_write();
    t_update_write();
    t_strobe();
    t_pass();
    t_pd();
    t_clr();
    t_clr_hold();
    t_frame();
    do_por(1'b1, "R1 por mid");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule